// File: doc/BRIEF.md
# Cartridge Bank Mapper

This block maps a larger external ROM and RAM into the narrow 16-bit address space of an 8-bit CPU. CPU writes that land in the lower half of the address space (0x0000–0x7FFF) never reach memory. They program a small set of control registers instead: a RAM gate, a ROM bank number, a RAM bank number (or two extra ROM bank bits) and a banking mode. From those registers and the current CPU address, the block forms the physical ROM address for a fixed 16 KiB window and a switchable 16 KiB window. It also forms the physical RAM address for the 8 KiB external RAM window, and it blocks RAM reads and writes while the RAM gate is closed.

A parameter picks one of two register personalities. In the split personality, the ROM bank is a 5-bit low field plus a 2-bit high field. The 2-bit register either feeds the high ROM bits or selects a RAM bank, depending on a mode bit. In the wide personality, the ROM bank is written as one 7-bit value and the RAM bank as a 3-bit value. Bank counts are parameters and must be powers of two. The stored bank number is reduced to the physical bank by masking with the bank count minus one.

Top module: `bank_mapper`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, the RAM gate is closed and the split personality is in ROM banking mode.
- R2: A strobed write to 0x0000–0x1FFF opens the RAM gate when data[3:0] equals 4'hA and closes it for every other value.
- R3: In the split personality, a write to 0x2000–0x3FFF replaces ROM bank bits [4:0] with data[4:0] and leaves bits [6:5] unchanged.
- R4: In the split personality, a write to 0x2000–0x3FFF whose resulting bank would be 0x00, 0x20, 0x40 or 0x60 yields that bank plus one.
- R5: In the split personality, a write to 0x4000–0x5FFF loads data[1:0] into the RAM bank when the mode bit is 1 (RAM mode), and into ROM bank bits [6:5] when it is 0 (ROM mode).
- R6: In the split personality, a write to 0x6000–0x7FFF sets the mode bit from data[0]. Setting it to 1 clears ROM bank bits [6:5]. Setting it to 0 forces the RAM bank to 0.
- R7: In the wide personality, a write to 0x2000–0x3FFF sets the ROM bank to data[6:0], with 0 replaced by 1. A write to 0x4000–0x5FFF sets the RAM bank to data[2:0]. Writes to 0x6000–0x7FFF change nothing.
- R8: While the RAM gate is closed, the CPU read data for the RAM window 0xA000–0xBFFF is 8'hFF and neither the RAM write enable nor the RAM output enable is raised. While it is open, the read data is the external RAM data and a strobed write in the window raises the write enable.
- R9: ROM addresses 0x0000–0x3FFF map to physical {0, addr[13:0]}. Addresses 0x4000–0x7FFF map to {bank & (ROM_BANKS-1), addr[13:0]}. The ROM select is high for addresses below 0x8000.
- R10: The RAM address is {ram_bank & (RAM_BANKS-1), addr[12:0]}, and the RAM select is high exactly for 0xA000–0xBFFF.
- R11: Registers change only on a clock edge with the write strobe high and the address below 0x8000. Writes at 0x8000 and above, or cycles with the strobe low, leave all mapping state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising clock edge |
| ram_rdata | input | 8 | Read data from external RAM |
| rom_cs | output | 1 | ROM select (address below 0x8000) |
| rom_addr | output | ROM_AW | Physical ROM address |
| ram_cs | output | 1 | RAM window select |
| ram_addr | output | RAM_AW | Physical RAM address |
| ram_we | output | 1 | External RAM write enable |
| ram_oe | output | 1 | External RAM output enable |
| cpu_ram_rdata | output | 8 | Data returned to the CPU for the RAM window |

## Verification
The bench targets the bank-zero substitution at 0x00, 0x20, 0x40 and 0x60. A design that checked only for 0x00 would map bank 0x20 to 0x20 rather than 0x21. It also targets the side effects of switching mode. A missed clear of the high ROM bits would leave the switchable window in a distant bank, and a missed RAM-bank reset would leave later RAM accesses in the wrong page. Masking is tested with a 64-bank ROM, where 0x41 must fold onto bank 1. The bench also covers the gate nibble test, where a design that compared the whole byte would reject 0x3A, and writes outside the control range, which must leave every bank untouched.

// File: rtl/bank_mapper_pkg.sv
// Shared definitions for the bank mapper.
// Assumes a 16-bit CPU address and 8-bit data.
package bank_mapper_pkg;

    // Which control register a write in 0x0000-0x7FFF targets (addr[14:13]).
    typedef enum logic [1:0] {
        SEL_GATE  = 2'd0,
        SEL_ROMLO = 2'd1,
        SEL_HIGH  = 2'd2,
        SEL_MODE  = 2'd3
    } ctrl_sel_e;

    // Register personality.
    localparam int FLAVOR_SPLIT = 0;
    localparam int FLAVOR_WIDE  = 1;

    localparam int ROM_OFS_W = 14;   // 16 KiB window
    localparam int RAM_OFS_W = 13;   // 8 KiB window
    localparam int BANK_W    = 7;    // stored ROM bank width
    localparam int RBANK_W   = 3;    // stored RAM bank width
    localparam logic [3:0] GATE_KEY = 4'hA;

endpackage

// File: rtl/mapper_decode.sv
// Address decoder for the bank mapper.
// Splits the CPU address into the control-write target, the ROM and RAM
// selects and the fixed-window flag. Purely combinational.
module mapper_decode
    import bank_mapper_pkg::*;
(
    input  logic [15:13] addr_hi,
    input  logic         wr,
    output logic         ctrl_wr,
    output ctrl_sel_e    ctrl_sel,
    output logic         rom_sel,
    output logic         rom_fixed,
    output logic         ram_sel
);

    // Classify the address into its windows.
    always_comb begin
        rom_sel   = ~addr_hi[15];
        rom_fixed = (addr_hi[15:14] == 2'b00);
        ram_sel   = (addr_hi == 3'b101);
        ctrl_wr   = wr & ~addr_hi[15];
        ctrl_sel  = ctrl_sel_e'(addr_hi[14:13]);
    end

endmodule

// File: rtl/mapper_ctrl_regs.sv
// Control registers of the bank mapper.
// Holds the RAM gate, ROM bank, RAM bank and mode bit. FLAVOR selects the
// split (5+2 bit) or wide (7 bit) register personality. The stored ROM
// bank never reads 0 in its low field, so no remap is needed downstream.
module mapper_ctrl_regs
    import bank_mapper_pkg::*;
#(
    parameter int FLAVOR = FLAVOR_SPLIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  ctrl_sel_e          ctrl_sel,
    input  logic [7:0]         wdata,
    output logic [BANK_W-1:0]  rom_bank,
    output logic [RBANK_W-1:0] ram_bank,
    output logic               ram_on,
    output logic               ram_mode
);

    logic key_hit;
    assign key_hit = (wdata[3:0] == GATE_KEY);

    // RAM gate: shared by both personalities.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ram_on <= 1'b0;
        else if (ctrl_wr && ctrl_sel == SEL_GATE)
            ram_on <= key_hit;
    end

    generate
        if (FLAVOR == FLAVOR_SPLIT) begin : g_split
            logic [4:0] lo_next;
            assign lo_next = (wdata[4:0] == 5'd0) ? 5'd1 : wdata[4:0];

            // Bank and mode registers for the split personality.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rom_bank <= BANK_W'(1);
                    ram_bank <= '0;
                    ram_mode <= 1'b0;
                end else if (ctrl_wr) begin
                    case (ctrl_sel)
                        SEL_ROMLO: rom_bank[4:0] <= lo_next;
                        SEL_HIGH: begin
                            if (ram_mode)
                                ram_bank <= {1'b0, wdata[1:0]};
                            else
                                rom_bank[6:5] <= wdata[1:0];
                        end
                        SEL_MODE: begin
                            ram_mode <= wdata[0];
                            if (wdata[0])
                                rom_bank[6:5] <= 2'b00;
                            else
                                ram_bank <= '0;
                        end
                        default: ;
                    endcase
                end
            end
        end else begin : g_wide
            logic [6:0] bank_next;
            assign bank_next = (wdata[6:0] == 7'd0) ? 7'd1 : wdata[6:0];
            assign ram_mode  = 1'b0;

            // Bank registers for the wide personality; mode writes are no-ops.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rom_bank <= BANK_W'(1);
                    ram_bank <= '0;
                end else if (ctrl_wr) begin
                    case (ctrl_sel)
                        SEL_ROMLO: rom_bank <= bank_next;
                        SEL_HIGH:  ram_bank <= wdata[2:0];
                        default: ;
                    endcase
                end
            end
        end
    endgenerate

endmodule

// File: rtl/mapper_addr_map.sv
// Physical address formation and RAM gating for the bank mapper.
// Masks the stored bank numbers to the configured bank counts (powers of
// two, at least 2) and builds ROM/RAM addresses. Purely combinational.
module mapper_addr_map
    import bank_mapper_pkg::*;
#(
    parameter int ROM_BANKS = 128,
    parameter int RAM_BANKS = 4,
    localparam int ROM_BW = $clog2(ROM_BANKS),
    localparam int RAM_BW = $clog2(RAM_BANKS),
    localparam int ROM_AW = ROM_BW + ROM_OFS_W,
    localparam int RAM_AW = RAM_BW + RAM_OFS_W
) (
    input  logic [15:0]        cpu_addr,
    input  logic               cpu_wr,
    input  logic [7:0]         ram_rdata,
    input  logic [BANK_W-1:0]  rom_bank,
    input  logic [RBANK_W-1:0] ram_bank,
    input  logic               ram_on,
    input  logic               rom_fixed,
    input  logic               ram_sel,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic [RAM_AW-1:0]  ram_addr,
    output logic               ram_we,
    output logic               ram_oe,
    output logic [7:0]         cpu_ram_rdata
);

    logic [15:0]       rom_ext;
    logic [15:0]       ram_ext;
    logic [ROM_BW-1:0] rom_phys;
    logic [RAM_BW-1:0] ram_phys;

    // Reduce bank numbers to the physical bank count.
    always_comb begin
        rom_ext  = 16'(rom_bank);
        ram_ext  = 16'(ram_bank);
        rom_phys = rom_ext[ROM_BW-1:0];
        ram_phys = ram_ext[RAM_BW-1:0];
    end

    // Build the physical addresses.
    always_comb begin
        if (rom_fixed)
            rom_addr = {{ROM_BW{1'b0}}, cpu_addr[ROM_OFS_W-1:0]};
        else
            rom_addr = {rom_phys, cpu_addr[ROM_OFS_W-1:0]};
        ram_addr = {ram_phys, cpu_addr[RAM_OFS_W-1:0]};
    end

    // Gate RAM access on the enable register.
    always_comb begin
        ram_oe        = ram_sel & ram_on;
        ram_we        = ram_sel & ram_on & cpu_wr;
        cpu_ram_rdata = ram_oe ? ram_rdata : 8'hFF;
    end

endmodule

// File: rtl/bank_mapper.sv
// Top level of the cartridge bank mapper.
// CPU writes below 0x8000 program the control registers; outputs are
// combinational from the registers and the current CPU address.
// Assumes ROM_BANKS in 2..128 and RAM_BANKS in 2..8, both powers of two.
module bank_mapper
    import bank_mapper_pkg::*;
#(
    parameter int FLAVOR    = FLAVOR_SPLIT,
    parameter int ROM_BANKS = 128,
    parameter int RAM_BANKS = 4,
    localparam int ROM_AW = $clog2(ROM_BANKS) + ROM_OFS_W,
    localparam int RAM_AW = $clog2(RAM_BANKS) + RAM_OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic [7:0]        ram_rdata,
    output logic              rom_cs,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              ram_cs,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic              ram_oe,
    output logic [7:0]        cpu_ram_rdata
);

    logic               ctrl_wr;
    ctrl_sel_e          ctrl_sel;
    logic               rom_fixed;
    logic               ram_sel;
    logic [BANK_W-1:0]  rom_bank_q;
    logic [RBANK_W-1:0] ram_bank_q;
    logic               ram_on_q;
    logic               ram_mode_q;

    mapper_decode u_decode (
        .addr_hi   (cpu_addr[15:13]),
        .wr        (cpu_wr),
        .ctrl_wr   (ctrl_wr),
        .ctrl_sel  (ctrl_sel),
        .rom_sel   (rom_cs),
        .rom_fixed (rom_fixed),
        .ram_sel   (ram_sel)
    );

    mapper_ctrl_regs #(.FLAVOR(FLAVOR)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .ctrl_sel (ctrl_sel),
        .wdata    (cpu_wdata),
        .rom_bank (rom_bank_q),
        .ram_bank (ram_bank_q),
        .ram_on   (ram_on_q),
        .ram_mode (ram_mode_q)
    );

    mapper_addr_map #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) u_map (
        .cpu_addr      (cpu_addr),
        .cpu_wr        (cpu_wr),
        .ram_rdata     (ram_rdata),
        .rom_bank      (rom_bank_q),
        .ram_bank      (ram_bank_q),
        .ram_on        (ram_on_q),
        .rom_fixed     (rom_fixed),
        .ram_sel       (ram_sel),
        .rom_addr      (rom_addr),
        .ram_addr      (ram_addr),
        .ram_we        (ram_we),
        .ram_oe        (ram_oe),
        .cpu_ram_rdata (cpu_ram_rdata)
    );

    assign ram_cs = ram_sel;

endmodule

// File: rtl/bank_mapper_chk.sv
// Assertion checker for bank_mapper, attached by bind.
// Observes ports and the control registers of the top module.
module bank_mapper_chk #(
    parameter int FLAVOR = 0
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        mode_bit,
    input logic        cpu_wr,
    input logic        ram_we,
    input logic        ram_oe,
    input logic [7:0]  cpu_ram_rdata,
    input logic [6:0]  rom_bank,
    input logic [2:0]  ram_bank,
    input logic        ram_on,
    input logic        ram_mode
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rom_bank == 7'd1 && ram_bank == 3'd0 && !ram_on && !ram_mode));

    // R8
    gate_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_on |-> (cpu_ram_rdata == 8'hFF && !ram_oe));

    // R8
    gate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_on && cpu_wr));

    // R11
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (!$past(cpu_wr) || $past(cpu_addr[15])))
        |-> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_on) && $stable(ram_mode)));

    generate
        if (FLAVOR == 0) begin : g_split_chk
            // R4
            no_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rom_bank[4:0] != 5'd0);

            // R6
            mode_rom_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(cpu_wr) && $past(cpu_addr[15:13]) == 3'b011 && !$past(mode_bit))
                |-> (ram_bank == 3'd0 && !ram_mode));

            // R6
            mode_ram_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(cpu_wr) && $past(cpu_addr[15:13]) == 3'b011 && $past(mode_bit))
                |-> (rom_bank[6:5] == 2'b00 && ram_mode));
        end else begin : g_wide_chk
            // R7
            no_zero_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rom_bank != 7'd0);
        end
    endgenerate

endmodule

bind bank_mapper bank_mapper_chk #(.FLAVOR(FLAVOR)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_addr      (cpu_addr),
    .mode_bit      (cpu_wdata[0]),
    .cpu_wr        (cpu_wr),
    .ram_we        (ram_we),
    .ram_oe        (ram_oe),
    .cpu_ram_rdata (cpu_ram_rdata),
    .rom_bank      (rom_bank_q),
    .ram_bank      (ram_bank_q),
    .ram_on        (ram_on_q),
    .ram_mode      (ram_mode_q)
);

// File: tb/bank_mapper_tb.sv
// Bench: one split-personality mapper (64 ROM banks, 4 RAM banks) and one
// wide-personality mapper (128 ROM banks, 8 RAM banks) share the stimulus.
module bank_mapper_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  ram_rdata = '0;

    logic        s_rom_cs, s_ram_cs, s_ram_we, s_ram_oe;
    logic [19:0] s_rom_addr;
    logic [14:0] s_ram_addr;
    logic [7:0]  s_rdata;
    logic        w_rom_cs, w_ram_cs, w_ram_we, w_ram_oe;
    logic [20:0] w_rom_addr;
    logic [15:0] w_ram_addr;
    logic [7:0]  w_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state.
    logic [6:0] m_rom;  logic [1:0] m_ram; logic m_on; logic m_mode;
    logic [6:0] n_rom;  logic [2:0] n_ram; logic n_on;

    always #5 clk = ~clk;

    bank_mapper #(.FLAVOR(0), .ROM_BANKS(64), .RAM_BANKS(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .ram_rdata(ram_rdata), .rom_cs(s_rom_cs),
        .rom_addr(s_rom_addr), .ram_cs(s_ram_cs), .ram_addr(s_ram_addr),
        .ram_we(s_ram_we), .ram_oe(s_ram_oe), .cpu_ram_rdata(s_rdata));

    bank_mapper #(.FLAVOR(1), .ROM_BANKS(128), .RAM_BANKS(8)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .ram_rdata(ram_rdata), .rom_cs(w_rom_cs),
        .rom_addr(w_rom_addr), .ram_cs(w_ram_cs), .ram_addr(w_ram_addr),
        .ram_we(w_ram_we), .ram_oe(w_ram_oe), .cpu_ram_rdata(w_rdata));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit in_ram_win(input logic [15:0] a);
        return a >= 16'hA000 && a <= 16'hBFFF;
    endfunction

    // Update the reference after a strobed write.
    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a < 16'h2000) begin
            m_on = (d[3:0] == 4'hA);
            n_on = m_on;
        end else if (a < 16'h4000) begin
            m_rom = {m_rom[6:5], d[4:0]};
            if (m_rom == 7'h00 || m_rom == 7'h20 || m_rom == 7'h40 || m_rom == 7'h60)
                m_rom = m_rom + 7'd1;
            n_rom = (d[6:0] == 0) ? 7'd1 : d[6:0];
        end else if (a < 16'h6000) begin
            if (m_mode) m_ram = d[1:0];
            else        m_rom = {d[1:0], m_rom[4:0]};
            n_ram = d[2:0];
        end else if (a < 16'h8000) begin
            m_mode = d[0];
            if (m_mode) m_rom = m_rom & 7'h1F;
            else        m_ram = 2'd0;
        end
    endtask

    // Drive one strobed write; check the write enables during the strobe.
    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        #1;
        chk("R8 split ram_we", int'(s_ram_we), int'(in_ram_win(a) && m_on));
        chk("R8 wide ram_we",  int'(w_ram_we), int'(in_ram_win(a) && n_on));
        @(negedge clk);
        cpu_wr = 1'b0;
        model_write(a, d);
    endtask

    // Apply an address with the strobe low and compare every output.
    task automatic probe(input string tag, input logic [15:0] a, input logic [7:0] rd);
        logic [19:0] e_srom;
        logic [20:0] e_wrom;
        cpu_addr = a; ram_rdata = rd; cpu_wr = 1'b0;
        #1;
        e_srom = (a[15:14] == 2'b00) ? {6'd0, a[13:0]} : {m_rom[5:0], a[13:0]};
        e_wrom = (a[15:14] == 2'b00) ? {7'd0, a[13:0]} : {n_rom, a[13:0]};
        chk({tag, " R9 split rom_cs"}, int'(s_rom_cs), int'(!a[15]));
        if (!a[15]) begin
            chk({tag, " R9 split rom_addr"}, int'(s_rom_addr), int'(e_srom));
            chk({tag, " R9 wide rom_addr"},  int'(w_rom_addr), int'(e_wrom));
        end
        chk({tag, " R10 split ram_cs"},   int'(s_ram_cs), int'(in_ram_win(a)));
        chk({tag, " R10 split ram_addr"}, int'(s_ram_addr), int'({m_ram, a[12:0]}));
        chk({tag, " R10 wide ram_addr"},  int'(w_ram_addr), int'({n_ram, a[12:0]}));
        chk({tag, " R8 split rdata"}, int'(s_rdata), (in_ram_win(a) && m_on) ? int'(rd) : 8'hFF);
        chk({tag, " R8 wide rdata"},  int'(w_rdata), (in_ram_win(a) && n_on) ? int'(rd) : 8'hFF);
        chk({tag, " R8 split ram_oe"}, int'(s_ram_oe), int'(in_ram_win(a) && m_on));
    endtask

    task automatic probe_all(input string tag);
        probe(tag, 16'h4000 | 16'($urandom_range(0, 16'h3FFF)), 8'h5A);
        probe(tag, 16'h0000 | 16'($urandom_range(0, 16'h3FFF)), 8'h00);
        probe(tag, 16'hA000 | 16'($urandom_range(0, 16'h1FFF)), 8'($urandom));
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        m_rom = 7'd1; m_ram = 2'd0; m_on = 1'b0; m_mode = 1'b0;
        n_rom = 7'd1; n_ram = 3'd0; n_on = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        probe("R1", 16'h4123, 8'h3C);
        probe("R1", 16'hA010, 8'h3C);

        // R2 gate key on low nibble
        do_write(16'h0000, 8'h0A); probe("R2", 16'hA555, 8'hC3);
        do_write(16'h1FFF, 8'h3A); probe("R2", 16'hB000, 8'h11);
        do_write(16'hA123, 8'h77);
        do_write(16'h0100, 8'hA0); probe("R2", 16'hA000, 8'h22);
        do_write(16'hBFFF, 8'h99);

        // R4 / R7 zero bank remap
        do_write(16'h2000, 8'h00); probe("R4 R7", 16'h7FFF, 8'h00);
        do_write(16'h2000, 8'h80); probe("R7", 16'h4000, 8'h00);
        // R5 high bits in ROM mode, R9 masking to 64 banks
        do_write(16'h4000, 8'h02); probe("R5 R9", 16'h4001, 8'h00);
        do_write(16'h2000, 8'h20); probe("R4", 16'h5000, 8'h00);
        do_write(16'h4000, 8'h01); probe("R5", 16'h6000, 8'h00);
        do_write(16'h2000, 8'h40); probe("R4", 16'h6000, 8'h00);
        do_write(16'h3FFF, 8'h13); probe("R3", 16'h4ABC, 8'h00);
        // R6 entering RAM mode clears high ROM bits
        do_write(16'h4000, 8'h03); do_write(16'h6000, 8'h01); probe("R6", 16'h4000, 8'h00);
        do_write(16'h5000, 8'h03); probe("R5", 16'hA000, 8'h00);
        // R6 entering ROM mode zeroes RAM bank; R7 wide ignores mode write
        do_write(16'h7000, 8'h00); probe("R6 R7", 16'hA000, 8'h00);
        // R11 writes above 0x7FFF and strobe-low cycles
        do_write(16'h8000, 8'h00); do_write(16'hC000, 8'h0A); do_write(16'hFFFF, 8'h01);
        probe("R11", 16'h4000, 8'h00);
        @(negedge clk); cpu_addr = 16'h2000; cpu_wdata = 8'h05;
        @(negedge clk); probe("R11", 16'h4000, 8'h00);
        do_write(16'h2000, 8'h7F); probe("R7", 16'h7000, 8'h00);
        do_write(16'h4000, 8'h07); probe("R7", 16'hA000, 8'h00);

        // Random phase with biased regions and data.
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            case ($urandom_range(0, 5))
                0, 1, 2: a = 16'($urandom_range(0, 16'h7FFF));
                3:       a = 16'hA000 | 16'($urandom_range(0, 16'h1FFF));
                4:       a = 16'h8000 | 16'($urandom_range(0, 16'h1FFF));
                default: a = 16'hC000 | 16'($urandom_range(0, 16'h3FFF));
            endcase
            case ($urandom_range(0, 3))
                0:       d = 8'(8'h20 * $urandom_range(0, 7));
                1:       d = {4'($urandom), 4'hA};
                default: d = 8'($urandom);
            endcase
            do_write(a, d);
            if (i % 4 == 0) probe_all("R3 R4 R5 R6 R7 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule